// File: doc/BRIEF.md
# Rotate and Wraparound Mask Unit

This block is the datapath for rotate-left-then-mask operations. A source word is rotated left circularly by an amount taken either from a 5-bit immediate field or from the low bits of a register operand. A mask is then built from a begin index and an end index. Bit positions count from 0 at the most significant bit. If the begin index is greater than the end index, the mask wraps around both ends of the word.

In plain mode the rotated word is ANDed with the mask. In insert mode the masked rotated bits replace the corresponding bits of a target word, and the bits of the target outside the mask are kept. A negative and zero flag pair is produced for the condition-recording form of the operation. The result and the flags are registered by default. A parameter selects a purely combinational variant instead. Instruction decode and register file access belong to the surrounding pipeline.

Top module: `rotmask_unit`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid`, `result`, `flag_neg` and `flag_zero` are all 0 until the first accepted operation.
- R2: The rotated value is `src` rotated left circularly by n places. Bit `i` of the source moves to bit `(i+n) mod 32`. An amount of 0 returns `src` unchanged.
- R3: When `amt_sel` is 1, the amount is the low 5 bits of `amt_reg`, and its upper 27 bits and `amt_imm` are ignored. When `amt_sel` is 0, the amount is `amt_imm`.
- R4: When `mask_begin <= mask_end`, the mask has ones at positions begin through end inclusive, and zeros elsewhere. Position p is bit `31-p`, so position 0 is the MSB.
- R5: When `mask_begin > mask_end`, the mask has ones at positions `p >= begin` and `p <= end`, and zeros at positions end+1 through begin-1.
- R6: Equal begin and end give a mask with exactly one bit set. Begin 0 with end 31 gives all ones.
- R7: With `insert_en` at 0, the result is the rotated value AND the mask, and `target` has no effect.
- R8: With `insert_en` at 1, the result is (rotated AND mask) OR (`target` AND NOT mask).
- R9: With `record_en` at 1, `flag_neg` equals bit 31 of the result, and `flag_zero` is 1 exactly when the result is 0. With `record_en` at 0, both flags are 0.
- R10: An operation presented with `in_valid` high at a rising edge appears on `result`, the flags and `out_valid` after that edge. In a cycle with `in_valid` low, `out_valid` is 0 and the result and flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| src | input | 32 | Word to rotate |
| amt_imm | input | 5 | Immediate rotate amount |
| amt_reg | input | 32 | Register operand holding the rotate amount in its low bits |
| amt_sel | input | 1 | 0: use `amt_imm`, 1: use `amt_reg` |
| mask_begin | input | 5 | First mask position (0 = MSB) |
| mask_end | input | 5 | Last mask position (0 = MSB) |
| insert_en | input | 1 | Merge into `target` instead of clearing unmasked bits |
| target | input | 32 | Existing value used in insert mode |
| record_en | input | 1 | Produce the condition flags |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 32 | Rotated and masked word |
| flag_neg | output | 1 | Result MSB when recording |
| flag_zero | output | 1 | Result is zero when recording |

## Verification
A faulty barrel stage corrupts every result whose amount has that bit set. The bench sees it on `result` one cycle after the operation is accepted, in the sweep over all 32 amounts with an all-ones mask. A faulty mask comparator or a wrong bit-numbering direction shows up in the first affected begin/end pair of the exhaustive 1024-pair sweep, either as a misplaced edge or as a wrap mask that is missing its ends. A merge or flag fault shows on the same cycle as the result it belongs to. A fault in the hold logic shows in the first idle cycle after an operation.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
   // Default datapath width; the index width derives from it.
   localparam int DEF_WIDTH = 32;

   typedef enum logic {
      AMT_FROM_IMM = 1'b0,
      AMT_FROM_REG = 1'b1
   } amt_src_e;

   typedef struct packed {
      logic neg;
      logic zero;
   } cond_flags_t;
endpackage

// File: rtl/rotmask_rotator.sv
module rotmask_rotator #(
   parameter int WIDTH = 32,
   localparam int IW = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] data_in,
   input  logic [IW-1:0]    amount,
   output logic [WIDTH-1:0] data_out
);
   // One stage per amount bit; stage k rotates left by 2**k when bit k is set.
   logic [WIDTH-1:0] stage [0:IW];

   assign stage[0] = data_in;

   for (genvar k = 0; k < IW; k++) begin : g_stage
      localparam int DIST = 2 ** k;
      logic [WIDTH-1:0] turned;
      assign turned = {stage[k][WIDTH-1-DIST:0], stage[k][WIDTH-1:WIDTH-DIST]};
      assign stage[k+1] = amount[k] ? turned : stage[k];
   end

   assign data_out = stage[IW];
endmodule

// File: rtl/rotmask_maskgen.sv
module rotmask_maskgen #(
   parameter int WIDTH = 32,
   localparam int IW = $clog2(WIDTH)
) (
   input  logic [IW-1:0]    first_pos,
   input  logic [IW-1:0]    last_pos,
   output logic [WIDTH-1:0] mask
);
   logic wraps;
   assign wraps = first_pos > last_pos;

   // Position p is counted from the MSB, so it lands on bit WIDTH-1-p.
   for (genvar p = 0; p < WIDTH; p++) begin : g_pos
      localparam logic [IW-1:0] POS = IW'(p);
      logic at_or_after_first;
      logic at_or_before_last;
      assign at_or_after_first = POS >= first_pos;
      assign at_or_before_last = POS <= last_pos;
      assign mask[WIDTH-1-p] = wraps ? (at_or_after_first | at_or_before_last)
                                     : (at_or_after_first & at_or_before_last);
   end
endmodule

// File: rtl/rotmask_merge.sv
module rotmask_merge
   import rotmask_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] rotated,
   input  logic [WIDTH-1:0] mask,
   input  logic [WIDTH-1:0] target,
   input  logic             insert_en,
   input  logic             record_en,
   output logic [WIDTH-1:0] merged,
   output cond_flags_t      flags
);
   logic [WIDTH-1:0] kept;

   assign kept   = insert_en ? (target & ~mask) : '0;
   assign merged = (rotated & mask) | kept;

   always_comb begin
      flags.neg  = record_en & merged[WIDTH-1];
      flags.zero = record_en & (merged == '0);
   end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
   import rotmask_pkg::*;
#(
   parameter int WIDTH        = DEF_WIDTH,
   parameter bit REGISTER_OUT = 1'b1,
   localparam int IW = $clog2(WIDTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [WIDTH-1:0] src,
   input  logic [IW-1:0]    amt_imm,
   input  logic [WIDTH-1:0] amt_reg,
   input  logic             amt_sel,
   input  logic [IW-1:0]    mask_begin,
   input  logic [IW-1:0]    mask_end,
   input  logic             insert_en,
   input  logic [WIDTH-1:0] target,
   input  logic             record_en,
   output logic             out_valid,
   output logic [WIDTH-1:0] result,
   output logic             flag_neg,
   output logic             flag_zero
);
   // Elaboration-time parameter checks.
   if (WIDTH < 4 || (1 << IW) != WIDTH) begin : g_bad_width
      $error("rotmask_unit: WIDTH must be a power of two of at least 4");
   end

   logic [IW-1:0]    amount;
   logic [WIDTH-1:0] rot_w;
   logic [WIDTH-1:0] mask_w;
   logic [WIDTH-1:0] res_w;
   cond_flags_t      flags_w;
   logic             amt_reg_unused;

   // Only the low index bits of a register-sourced amount matter.
   assign amount = (amt_src_e'(amt_sel) == AMT_FROM_REG) ? amt_reg[IW-1:0] : amt_imm;
   assign amt_reg_unused = ^amt_reg[WIDTH-1:IW];

   rotmask_rotator #(.WIDTH(WIDTH)) rot_i (
      .data_in (src),
      .amount  (amount),
      .data_out(rot_w)
   );

   rotmask_maskgen #(.WIDTH(WIDTH)) mask_i (
      .first_pos(mask_begin),
      .last_pos (mask_end),
      .mask     (mask_w)
   );

   rotmask_merge #(.WIDTH(WIDTH)) merge_i (
      .rotated  (rot_w),
      .mask     (mask_w),
      .target   (target),
      .insert_en(insert_en),
      .record_en(record_en),
      .merged   (res_w),
      .flags    (flags_w)
   );

   if (REGISTER_OUT) begin : g_reg
      logic             valid_q;
      logic [WIDTH-1:0] result_q;
      cond_flags_t      flags_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q  <= 1'b0;
            result_q <= '0;
            flags_q  <= '0;
         end else begin
            valid_q <= in_valid;
            if (in_valid) begin
               result_q <= res_w;
               flags_q  <= flags_w;
            end
         end
      end

      assign out_valid = valid_q;
      assign result    = result_q;
      assign flag_neg  = flags_q.neg;
      assign flag_zero = flags_q.zero;

      AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> out_valid); // R10
      AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> (!out_valid && $stable(result) && $stable(flag_zero))); // R10
      AST_ROT_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |-> ($countones(rot_w) == $countones(src))); // R2
      AST_ROT_ZERO_AMOUNT: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && amount == '0) |-> (rot_w == src)); // R2
      AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |-> (mask_w != '0)); // R5
      AST_MASK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && mask_begin == mask_end) |-> ($countones(mask_w) == 1)); // R6
      AST_PLAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !insert_en) |-> ((res_w & ~mask_w) == '0)); // R7
      AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         flag_zero |-> (result == '0)); // R9
      AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
         flag_neg |-> result[WIDTH-1]); // R9
   end else begin : g_comb
      assign out_valid = in_valid;
      assign result    = res_w;
      assign flag_neg  = flags_w.neg;
      assign flag_zero = flags_w.zero;
   end
endmodule

// File: tb/rotmask_unit_tb.sv
module rotmask_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] src = '0;
   logic [4:0]  amt_imm = '0;
   logic [31:0] amt_reg = '0;
   logic        amt_sel = 1'b0;
   logic [4:0]  mask_begin = '0;
   logic [4:0]  mask_end = '0;
   logic        insert_en = 1'b0;
   logic [31:0] target = '0;
   logic        record_en = 1'b0;
   logic        out_valid;
   logic [31:0] result;
   logic        flag_neg;
   logic        flag_zero;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk; // 50 MHz

   rotmask_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src),
      .amt_imm(amt_imm), .amt_reg(amt_reg), .amt_sel(amt_sel),
      .mask_begin(mask_begin), .mask_end(mask_end), .insert_en(insert_en),
      .target(target), .record_en(record_en), .out_valid(out_valid),
      .result(result), .flag_neg(flag_neg), .flag_zero(flag_zero)
   );

   function automatic logic [31:0] ref_rot(logic [31:0] x, int n);
      logic [63:0] d;
      d = {x, x} << n;
      return d[63:32];
   endfunction

   function automatic logic [31:0] ref_mask(int b, int e);
      logic [31:0] ones;
      ones = 32'hFFFF_FFFF;
      if (b <= e) return (ones >> b) & (ones << (31 - e));
      return ~((ones >> (e + 1)) & (ones << (32 - b)));
   endfunction

   function automatic logic [31:0] mix(int i);
      return (32'(i) * 32'h9E37_79B1) ^ 32'h1357_9BDF;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drive on a falling edge, sample on the next falling edge.
   task automatic run_op(logic [31:0] s, int n_imm, logic [31:0] rg, logic sel,
                         int b, int e, logic ins, logic [31:0] tg, logic rec);
      @(negedge clk);
      in_valid = 1'b1; src = s; amt_imm = 5'(n_imm); amt_reg = rg; amt_sel = sel;
      mask_begin = 5'(b); mask_end = 5'(e); insert_en = ins; target = tg;
      record_en = rec;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] exp_v;
      repeat (3) @(negedge clk);
      chk("R1 out_valid in reset", 32'(out_valid), 32'd0);
      chk("R1 result in reset", result, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 outputs after reset", {29'd0, out_valid, flag_neg, flag_zero}, 32'd0);
      chk("R1 result after reset", result, 32'd0);

      // R2: every amount with an all-ones mask, several sources
      for (int s = 0; s < 4; s++) begin
         for (int n = 0; n < 32; n++) begin
            logic [31:0] v;
            v = (s == 0) ? 32'h8000_0001 : mix(s * 40 + n);
            run_op(v, n, 32'hFFFF_FFE0, 1'b0, 0, 31, 1'b0, 32'h0, 1'b0);
            chk("R2 rotate", result, ref_rot(v, n));
         end
      end

      // R3: register amount with junk upper bits; immediate set to differ
      for (int n = 0; n < 32; n++) begin
         logic [31:0] v;
         v = mix(n + 500);
         run_op(v, 31 - n, {mix(n)[31:5], 5'(n)}, 1'b1, 0, 31, 1'b0, 32'h0, 1'b0);
         chk("R3 register amount", result, ref_rot(v, n));
      end

      // R4 R5 R6: all begin/end pairs, mask exposed through all-ones source
      for (int b = 0; b < 32; b++) begin
         for (int e = 0; e < 32; e++) begin
            run_op(32'hFFFF_FFFF, 0, 32'h0, 1'b0, b, e, 1'b0, 32'h0, 1'b0);
            if (b <= e) chk("R4 contiguous mask", result, ref_mask(b, e));
            else        chk("R5 wrap mask", result, ref_mask(b, e));
            if (b == e) chk("R6 single bit", 32'(result), 32'h8000_0000 >> b);
         end
      end
      run_op(32'hFFFF_FFFF, 0, 32'h0, 1'b0, 0, 31, 1'b0, 32'h0, 1'b0);
      chk("R6 full mask", result, 32'hFFFF_FFFF);

      // R7: target has no effect in plain mode
      for (int i = 0; i < 32; i++) begin
         logic [31:0] v;
         v = mix(i + 900);
         run_op(v, i, 32'h0, 1'b0, (i * 5) % 32, (i * 11) % 32, 1'b0, ~v, 1'b0);
         chk("R7 plain ignores target", result,
             ref_rot(v, i) & ref_mask((i * 5) % 32, (i * 11) % 32));
      end

      // R8: insert mode over all begin/end pairs
      for (int b = 0; b < 32; b++) begin
         for (int e = 0; e < 32; e++) begin
            logic [31:0] v, t, m;
            v = mix(b * 32 + e);
            t = mix(b * 32 + e + 4096);
            m = ref_mask(b, e);
            run_op(v, (b * 7 + e) % 32, 32'h0, 1'b0, b, e, 1'b1, t, 1'b0);
            chk("R8 insert", result, (ref_rot(v, (b * 7 + e) % 32) & m) | (t & ~m));
         end
      end

      // R9: flags
      run_op(32'h0000_00F0, 0, 32'h0, 1'b0, 0, 23, 1'b0, 32'h0, 1'b1);
      chk("R9 zero result flags", {30'd0, flag_neg, flag_zero}, 32'd1);
      run_op(32'h0000_0001, 1, 32'h0, 1'b0, 0, 31, 1'b0, 32'h0, 1'b1);
      chk("R9 positive flags", {30'd0, flag_neg, flag_zero}, 32'd0);
      run_op(32'h0000_0001, 31, 32'h0, 1'b0, 0, 31, 1'b0, 32'h0, 1'b1);
      chk("R9 negative flags", {30'd0, flag_neg, flag_zero}, 32'd2);
      run_op(32'h0000_0001, 31, 32'h0, 1'b0, 0, 31, 1'b0, 32'h0, 1'b0);
      chk("R9 no record negative", {30'd0, flag_neg, flag_zero}, 32'd0);
      run_op(32'h0, 0, 32'h0, 1'b0, 0, 31, 1'b0, 32'h0, 1'b0);
      chk("R9 no record zero", {30'd0, flag_neg, flag_zero}, 32'd0);
      run_op(32'h1234_0000, 0, 32'h0, 1'b0, 31, 0, 1'b1, 32'h7FFF_FFFF, 1'b1);
      exp_v = 32'h7FFF_FFFE;
      chk("R9 insert result", result, exp_v);
      chk("R9 insert flags", {30'd0, flag_neg, flag_zero}, 32'd0);

      // R10: valid timing and hold while idle
      run_op(32'hCAFE_F00D, 4, 32'h0, 1'b0, 0, 31, 1'b0, 32'h0, 1'b1);
      chk("R10 out_valid after op", 32'(out_valid), 32'd1);
      exp_v = ref_rot(32'hCAFE_F00D, 4);
      chk("R10 result after op", result, exp_v);
      in_valid = 1'b0; src = 32'h0; record_en = 1'b1;
      @(negedge clk);
      chk("R10 out_valid idle", 32'(out_valid), 32'd0);
      chk("R10 result held", result, exp_v);
      chk("R10 flags held", {30'd0, flag_neg, flag_zero}, {30'd0, exp_v[31], 1'b0});
      @(negedge clk);
      chk("R10 result held second idle", result, exp_v);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule